// File: doc/BRIEF.md
# Processor Reset Sequencer with Strap Capture

This block produces the core reset level for a simple processor front end and decides when that reset may end. Two causes put the core into reset. A power-good indication that goes low starts a cold reset. A warm request comes either as a synchronous one-cycle pulse or as a level on an external reset pin that may change at any time. A cold reset keeps the core in reset for a programmable number of milliseconds. The count only begins once power-good has passed its own synchronizer. A warm reset keeps it in reset for a fixed number of clocks. Any new request that arrives while the core is in reset starts the running hold count over.

On the clock edge where reset ends, the block captures two configuration strap pins into mode bits. One selects output drive strength and the other enables tri-state test. Both bits then stay fixed until the next release. While reset lasts, the fetch address is held at the boot vector. In the first cycle after release a single `fetch_start` pulse appears while the address still shows the vector. After that the address steps forward by four bytes on each cycle in which the fetcher accepts it.

The sequencer is a three-state machine: `ST_COLD`, `ST_WARM` and `ST_RUN`. Its transitions are named as follows.
- `power_drop` (any state to `ST_COLD`) happens asynchronously when power-good falls.
- `cold_restart` (`ST_COLD` to `ST_COLD`, hold count cleared) happens on any request.
- `cold_release` (`ST_COLD` to `ST_RUN`) happens when power-good is synchronized and the cold count is complete.
- `warm_entry` (`ST_RUN` to `ST_WARM`) happens on any request.
- `warm_restart` (`ST_WARM` to `ST_WARM`, hold count cleared) happens on any request.
- `warm_release` (`ST_WARM` to `ST_RUN`) happens when the warm count is complete.

Top module: `cpu_reset_sequencer`

## Requirements
- R1: A high level on `ext_rst_req` raises `core_reset` at once, without waiting for a clock. After the pin falls, it passes through a two-stage synchronizer and counts as a request on two more clock edges.
- R2: After `pwr_good` rises, `core_reset` stays high through rising edge COLD+1 and falls on rising edge COLD+2, where COLD = (CLK_FREQ_HZ/1000)*COLD_HOLD_MS. The two extra edges are the power-good synchronizer.
- R3: A `warm_req` pulse sampled high on a rising edge while running raises `core_reset` on that edge. Reset then falls exactly WARM_CYCLES (default 15) edges later.
- R4: Any request sampled while reset is active clears the hold count. In a warm reset, release comes WARM_CYCLES edges after the last request. In a cold reset, release comes COLD edges after the last request, so a warm request never shortens a cold hold.
- R5: On the edge where `core_reset` falls, `strap_drive` is stored into `drive_mode` and `strap_tristate` is stored into `tristate_test`.
- R6: Strap changes at any other time have no effect. The stored bits keep their values through later warm resets until the next release. A low `pwr_good` clears both bits to 0.
- R7: While reset is active, and in the first cycle after release, `fetch_addr` equals 32'hFFFF_FFF0.
- R8: `fetch_start` is high for exactly the one cycle after the release edge, and low otherwise.
- R9: While running, each edge with `fetch_adv` high adds 4 to `fetch_addr`, modulo 2^32. During reset, `fetch_adv` is ignored.
- R10: A low `pwr_good` asynchronously returns the block to its reset state. In that state `core_reset` is 1, `fetch_start` is 0, `fetch_addr` is the vector and both mode bits are 0. The next hold is a cold one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pwr_good | input | 1 | Clock and supply valid; low forces a cold reset |
| ext_rst_req | input | 1 | Asynchronous external reset level, active high |
| warm_req | input | 1 | Synchronous warm reset request, active high |
| strap_drive | input | 1 | Drive strength strap, captured at release |
| strap_tristate | input | 1 | Tri-state test strap, captured at release |
| fetch_adv | input | 1 | Fetcher accepted the current address |
| core_reset | output | 1 | Reset level to the core, active high |
| drive_mode | output | 1 | Latched drive strength mode bit |
| tristate_test | output | 1 | Latched tri-state test mode bit |
| fetch_addr | output | 32 | Current fetch address |
| fetch_start | output | 1 | One-cycle pulse marking first fetch after reset |

## Verification
A wrong hold counter or a wrong state transition shows up directly as a `core_reset` edge one or more cycles off the computed release edge. The bench catches this at the first sampled edge past the expected count. A strap register that loads in the wrong cycle gives a mode bit that differs from the strap value driven only in the release cycle. That difference is visible in the `fetch_start` cycle. An address register that runs during reset, or loses the vector, gives a wrong `fetch_addr` in the same `fetch_start` cycle. Errors in the advance path show within one or two cycles of fetch activity, including at the 32-bit wrap.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        ST_COLD = 2'd0,
        ST_WARM = 2'd1,
        ST_RUN  = 2'd2
    } rsq_state_e;

    localparam int          RSQ_ADDR_W      = 32;
    localparam logic [31:0] RSQ_BOOT_VECTOR = 32'hFFFF_FFF0;
    localparam int          RSQ_FETCH_STEP  = 4;

    function automatic int rsq_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int rsq_cold_cycles(input int freq_hz, input int hold_ms);
        int c;
        c = (freq_hz / 1000) * hold_ms;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain_q <= RST_VAL;
                else      chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain_q <= {STAGES{RST_VAL}};
                else      chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rsq_hold_timer.sv
module rsq_hold_timer #(
    parameter int COLD_CYCLES = 100000,
    parameter int WARM_CYCLES = 15,
    localparam int MAX_CYCLES = (COLD_CYCLES > WARM_CYCLES) ? COLD_CYCLES : WARM_CYCLES,
    localparam int CNT_W      = $clog2(MAX_CYCLES + 1)
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clr,
    input  logic inc,
    input  logic sel_cold,
    output logic at_limit
);

    localparam logic [CNT_W-1:0] COLD_LAST = CNT_W'(COLD_CYCLES - 1);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last     = sel_cold ? COLD_LAST : WARM_LAST;
        at_limit = (cnt_q == last);
    end

    // Counts held cycles; saturates at the selected limit.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && !at_limit) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rsq_boot_regs.sv
module rsq_boot_regs
    import rsq_pkg::*;
#(
    parameter int          ADDR_W      = RSQ_ADDR_W,
    parameter logic [31:0] BOOT_VECTOR = RSQ_BOOT_VECTOR,
    parameter int          FETCH_STEP  = RSQ_FETCH_STEP
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              release_i,
    input  logic              in_reset_i,
    input  logic              adv_i,
    input  logic              strap_drive_i,
    input  logic              strap_tri_i,
    output logic              drive_mode_o,
    output logic              tri_test_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              start_o
);

    localparam logic [ADDR_W-1:0] VEC  = ADDR_W'(BOOT_VECTOR);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(FETCH_STEP);

    // Strap mode bits: loaded only on the release edge.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            drive_mode_o <= 1'b0;
            tri_test_o   <= 1'b0;
        end else if (release_i) begin
            drive_mode_o <= strap_drive_i;
            tri_test_o   <= strap_tri_i;
        end
    end

    // First-fetch marker.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) start_o <= 1'b0;
        else         start_o <= release_i;
    end

    // Fetch address: pinned to the vector during reset.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            addr_o <= VEC;
        end else if (in_reset_i) begin
            addr_o <= VEC;
        end else if (adv_i) begin
            addr_o <= addr_o + STEP;
        end
    end

endmodule

// File: rtl/cpu_reset_sequencer.sv
module cpu_reset_sequencer
    import rsq_pkg::*;
#(
    parameter int          CLK_FREQ_HZ  = 100_000_000,
    parameter int          COLD_HOLD_MS = 1,
    parameter int          WARM_CYCLES  = 15,
    parameter int          SYNC_STAGES  = 2,
    parameter logic [31:0] BOOT_VECTOR  = RSQ_BOOT_VECTOR,
    parameter int          ADDR_W       = RSQ_ADDR_W
) (
    input  logic              clk,
    input  logic              pwr_good,
    input  logic              ext_rst_req,
    input  logic              warm_req,
    input  logic              strap_drive,
    input  logic              strap_tristate,
    input  logic              fetch_adv,
    output logic              core_reset,
    output logic              drive_mode,
    output logic              tristate_test,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_start
);

    localparam int COLD_CYCLES = rsq_cold_cycles(CLK_FREQ_HZ, COLD_HOLD_MS);

    rsq_state_e state_q, state_d;
    logic       pg_ok;
    logic       ext_hold;
    logic       restart;
    logic       tmr_clr, tmr_inc, tmr_sel_cold, tmr_at_limit;
    logic       release_now;

    // Power-good: asynchronous clear, synchronous qualification.
    rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
        .clk  (clk),
        .arst (~pwr_good),
        .din  (1'b1),
        .dout (pg_ok)
    );

    // External reset: asynchronous set, synchronous release.
    rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
        .clk  (clk),
        .arst (ext_rst_req | ~pwr_good),
        .din  (1'b0),
        .dout (ext_hold)
    );

    rsq_hold_timer #(.COLD_CYCLES(COLD_CYCLES), .WARM_CYCLES(WARM_CYCLES)) u_timer (
        .clk      (clk),
        .arst_n   (pwr_good),
        .clr      (tmr_clr),
        .inc      (tmr_inc),
        .sel_cold (tmr_sel_cold),
        .at_limit (tmr_at_limit)
    );

    assign restart = warm_req | ext_hold;

    // State register; power_drop enters ST_COLD asynchronously.
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) state_q <= ST_COLD;
        else           state_q <= state_d;
    end

    // Next-state and timer control.
    always_comb begin
        state_d      = state_q;
        tmr_clr      = 1'b0;
        tmr_inc      = 1'b0;
        tmr_sel_cold = 1'b0;
        release_now  = 1'b0;
        unique case (state_q)
            ST_COLD: begin
                tmr_sel_cold = 1'b1;
                if (restart) begin
                    tmr_clr = 1'b1;                    // cold_restart
                end else if (pg_ok && tmr_at_limit) begin
                    tmr_clr     = 1'b1;                // cold_release
                    release_now = 1'b1;
                    state_d     = ST_RUN;
                end else begin
                    tmr_inc = pg_ok;
                end
            end
            ST_WARM: begin
                if (restart) begin
                    tmr_clr = 1'b1;                    // warm_restart
                end else if (tmr_at_limit) begin
                    tmr_clr     = 1'b1;                // warm_release
                    release_now = 1'b1;
                    state_d     = ST_RUN;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            ST_RUN: begin
                tmr_clr = 1'b1;
                if (restart) state_d = ST_WARM;        // warm_entry
            end
            default: begin
                tmr_clr = 1'b1;
                state_d = ST_COLD;
            end
        endcase
    end

    // Output decode: external pin raises reset without a clock.
    always_comb begin
        core_reset = (state_q != ST_RUN) | ext_hold;
    end

    rsq_boot_regs #(
        .ADDR_W      (ADDR_W),
        .BOOT_VECTOR (BOOT_VECTOR),
        .FETCH_STEP  (RSQ_FETCH_STEP)
    ) u_boot (
        .clk           (clk),
        .arst_n        (pwr_good),
        .release_i     (release_now),
        .in_reset_i    (core_reset),
        .adv_i         (fetch_adv),
        .strap_drive_i (strap_drive),
        .strap_tri_i   (strap_tristate),
        .drive_mode_o  (drive_mode),
        .tri_test_o    (tristate_test),
        .addr_o        (fetch_addr),
        .start_o       (fetch_start)
    );

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
    parameter int          COLD  = 100000,
    parameter int          WARM  = 15,
    parameter int          AW    = 32,
    parameter logic [31:0] VEC   = 32'hFFFF_FFF0
) (
    input logic          clk,
    input logic          pwr_good,
    input logic          ext_rst_req,
    input logic          warm_req,
    input logic          strap_drive,
    input logic          strap_tristate,
    input logic          core_reset,
    input logic          drive_mode,
    input logic          tristate_test,
    input logic [AW-1:0] fetch_addr,
    input logic          fetch_start
);

    localparam int SAT   = ((COLD > WARM) ? COLD : WARM) + 4;
    localparam int CNT_W = $clog2(SAT + 1);

    logic [CNT_W-1:0] hold_len;
    logic [CNT_W-1:0] pg_len;

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            hold_len <= '0;
            pg_len   <= '0;
        end else begin
            if (!core_reset)                hold_len <= '0;
            else if (hold_len != CNT_W'(SAT)) hold_len <= hold_len + CNT_W'(1);
            if (pg_len != CNT_W'(SAT))        pg_len   <= pg_len + CNT_W'(1);
        end
    end

    a_r1_ext_forces_reset: assert property (@(posedge clk) disable iff (!pwr_good)
        ext_rst_req |-> core_reset);

    a_r2_cold_min: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(core_reset) |-> (pg_len >= CNT_W'(COLD)));

    a_r3_warm_min: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(core_reset) |-> (hold_len >= CNT_W'(WARM)));

    a_r3_request_enters_reset: assert property (@(posedge clk) disable iff (!pwr_good)
        warm_req |=> core_reset);

    a_r5_strap_capture: assert property (@(posedge clk) disable iff (!pwr_good)
        fetch_start |-> (drive_mode == $past(strap_drive)) && (tristate_test == $past(strap_tristate)));

    a_r6_strap_hold: assert property (@(posedge clk) disable iff (!pwr_good)
        !fetch_start |-> $stable(drive_mode) && $stable(tristate_test));

    a_r7_vector_in_reset: assert property (@(posedge clk) disable iff (!pwr_good)
        (core_reset && $past(core_reset)) |-> (fetch_addr == AW'(VEC)));

    a_r7_start_vector: assert property (@(posedge clk) disable iff (!pwr_good)
        fetch_start |-> (fetch_addr == AW'(VEC)) && !core_reset);

    a_r8_start_single: assert property (@(posedge clk) disable iff (!pwr_good)
        fetch_start |=> !fetch_start);

endmodule

bind cpu_reset_sequencer rsq_checker #(
    .COLD (COLD_CYCLES),
    .WARM (WARM_CYCLES),
    .AW   (ADDR_W),
    .VEC  (BOOT_VECTOR)
) u_rsq_checker (
    .clk            (clk),
    .pwr_good       (pwr_good),
    .ext_rst_req    (ext_rst_req),
    .warm_req       (warm_req),
    .strap_drive    (strap_drive),
    .strap_tristate (strap_tristate),
    .core_reset     (core_reset),
    .drive_mode     (drive_mode),
    .tristate_test  (tristate_test),
    .fetch_addr     (fetch_addr),
    .fetch_start    (fetch_start)
);

// File: tb/cpu_reset_sequencer_bench.sv
module cpu_reset_sequencer_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          FREQ       = 20_000;
    localparam int          C          = FREQ / 1000;
    localparam int          W          = 15;
    localparam logic [31:0] VEC        = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        pwr_good, ext_rst_req, warm_req;
    logic        strap_drive, strap_tristate, fetch_adv;
    logic        core_reset, drive_mode, tristate_test, fetch_start;
    logic [31:0] fetch_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_reset_sequencer #(
        .CLK_FREQ_HZ  (FREQ),
        .COLD_HOLD_MS (1),
        .WARM_CYCLES  (W)
    ) u_cpu_reset_sequencer (
        .clk            (clk),
        .pwr_good       (pwr_good),
        .ext_rst_req    (ext_rst_req),
        .warm_req       (warm_req),
        .strap_drive    (strap_drive),
        .strap_tristate (strap_tristate),
        .fetch_adv      (fetch_adv),
        .core_reset     (core_reset),
        .drive_mode     (drive_mode),
        .tristate_test  (tristate_test),
        .fetch_addr     (fetch_addr),
        .fetch_start    (fetch_start)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic edge_sample();
        @(posedge clk);
        #1;
    endtask

    // Checks after a release edge; s = {drive, tristate}.
    task automatic after_release(input logic [1:0] s, input string tag);
        check({tag, " R8 fetch_start pulse"}, 32'(fetch_start), 32'd1);
        check({tag, " R7 vector at start"}, fetch_addr, VEC);
        check({tag, " R5 drive_mode"}, 32'(drive_mode), 32'(s[1]));
        check({tag, " R5 tristate_test"}, 32'(tristate_test), 32'(s[0]));
        @(negedge clk);
        strap_drive    = ~s[1];
        strap_tristate = ~s[0];
        edge_sample();
        check({tag, " R8 pulse ends"}, 32'(fetch_start), 32'd0);
        check({tag, " R6 straps ignored"}, {30'd0, drive_mode, tristate_test}, 32'(s));
    endtask

    // Cold power-up; restart_at > 0 puts a warm request on that edge.
    task automatic cold_up(input int restart_at, input logic [1:0] s);
        int total;
        total = (restart_at > 0) ? restart_at + C : C + 2;
        @(negedge clk);
        pwr_good       = 1'b1;
        strap_drive    = ~s[1];
        strap_tristate = ~s[0];
        for (int n = 1; n <= total; n++) begin
            if (n > 1) @(negedge clk);
            warm_req = (n == restart_at);
            if (n == total) begin
                strap_drive    = s[1];
                strap_tristate = s[0];
            end
            edge_sample();
            if (n >= total - 2)
                check((restart_at > 0) ? "R4 cold restart hold" : "R2 cold hold",
                      32'(core_reset), 32'(n < total));
            else if (core_reset !== 1'b1)
                check("R2 early cold release", 32'(core_reset), 32'd1);
        end
        @(negedge clk);
        warm_req = 1'b0;
        #0;
        after_release(s, "cold");
    endtask

    // Warm request; restart_at > 0 repeats the request on that edge.
    task automatic warm_run(input int restart_at, input logic [1:0] s);
        int total;
        total = (restart_at > 0) ? restart_at + W : W;
        @(negedge clk);
        warm_req       = 1'b1;
        strap_drive    = ~s[1];
        strap_tristate = ~s[0];
        edge_sample();
        check("R3 reset on request", 32'(core_reset), 32'd1);
        for (int n = 1; n <= total; n++) begin
            @(negedge clk);
            warm_req = (n == restart_at);
            if (n == total) begin
                strap_drive    = s[1];
                strap_tristate = s[0];
            end
            edge_sample();
            if (n >= total - 1)
                check((restart_at > 0) ? "R4 warm restart hold" : "R3 warm hold",
                      32'(core_reset), 32'(n < total));
            else if (core_reset !== 1'b1)
                check("R3 early warm release", 32'(core_reset), 32'd1);
        end
        after_release(s, "warm");
    endtask

    initial begin
        pwr_good       = 1'b1;
        ext_rst_req    = 1'b0;
        warm_req       = 1'b0;
        strap_drive    = 1'b0;
        strap_tristate = 1'b0;
        fetch_adv      = 1'b0;
        #2 pwr_good = 1'b0;
        repeat (3) edge_sample();
        check("R10 reset core_reset", 32'(core_reset), 32'd1);
        check("R10 reset fetch_start", 32'(fetch_start), 32'd0);
        check("R10 reset fetch_addr", fetch_addr, VEC);
        check("R10 reset mode bits", {30'd0, drive_mode, tristate_test}, 32'd0);

        // Cold power-up, drive strap high.
        cold_up(0, 2'b10);

        // Fetch advance through the 32-bit wrap.
        @(negedge clk);
        fetch_adv = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            edge_sample();
            check("R9 fetch advance", fetch_addr, VEC + 32'(4 * k));
        end

        // Warm sweep: plain and restarted at every offset, all strap pairs.
        for (int r = 0; r < W; r++) begin
            warm_run(r, 2'(r));
            check("R9 advance after warm", fetch_addr, VEC + 32'd4);
        end

        // External asynchronous reset.
        @(negedge clk);
        ext_rst_req = 1'b1;
        #1;
        check("R1 async assert", 32'(core_reset), 32'd1);
        repeat (3) edge_sample();
        check("R9 adv ignored in reset", fetch_addr, VEC);
        @(negedge clk);
        ext_rst_req    = 1'b0;
        strap_drive    = 1'b1;
        strap_tristate = 1'b1;
        for (int n = 1; n <= W + 2; n++) begin
            edge_sample();
            if (n >= W + 1)
                check("R1 ext release timing", 32'(core_reset), 32'(n < W + 2));
            else if (core_reset !== 1'b1)
                check("R1 early ext release", 32'(core_reset), 32'd1);
        end
        check("R5 ext straps", {30'd0, drive_mode, tristate_test}, 32'd3);

        // Power drop: asynchronous return to the reset state.
        @(negedge clk);
        pwr_good = 1'b0;
        #1;
        check("R10 drop core_reset", 32'(core_reset), 32'd1);
        check("R6 drop clears modes", {30'd0, drive_mode, tristate_test}, 32'd0);
        check("R10 drop fetch_addr", fetch_addr, VEC);
        repeat (2) edge_sample();

        // Cold power-up with a warm request inside the cold hold.
        fetch_adv = 1'b0;
        cold_up(8, 2'b01);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule